// File: doc/BRIEF.md
# Cascaded Prescaler Reload Timer

This block is a programmable interval timer. An 8-bit prescaler down-counter divides a selected tick source, and each prescaler underflow steps an 8-bit main down-counter. Both counters have their own reload register. On underflow a counter reloads from its reload register and keeps counting. A main-counter underflow raises a sticky interrupt request flag. With the prescaler set to n and the main counter set to m, the flag is raised once every (n+1)(m+1) source ticks.

Software drives the block through a plain synchronous bus. A write takes effect on the clock edge where `bus_wr` is high. A read is combinational on `bus_addr`. The control register holds the following fields:

- bit 0: start bit.
- bit 1: write-mode bit.
- bits 3:2: tick-source select.
- bit 4: external edge select.
- bit 7: the interrupt flag.

The prescaler is at address 1 and the main counter at address 2. Reads of these two addresses return the live counter values. The tick source is one of four: every clock, every eighth clock, an on-chip oscillator enable, or edges of an external pin. The external pin is synchronized before its edges are detected.

Top module: `cascade_timer`

## Requirements
- R1: After reset the block is in this state. Control reads 0x00 (stopped, source 00, write mode 0, rising edge). The interrupt flag is 0. Both counters and both reload registers hold 0xFF. Address 3 reads 0x00.
- R2: Control bits 3:2 choose the tick source. 00 gives one tick every clock. 01 gives one tick every eighth clock. 10 gives one tick on each clock where `ring_en` is high. 11 gives external-pin edges.
- R3: The prescaler steps once per tick. The main counter steps only on a clock where the prescaler underflows. The interrupt flag is therefore set (n+1)(m+1) ticks after starting from prescaler value n and main value m.
- R4: A counter at 0 that receives a step loads its reload register value. It then keeps counting down from there.
- R5: While control bit 0 (start) is 0, neither counter changes, except through a direct write.
- R6: A main-counter underflow sets the interrupt flag (control bit 7) on the next clock.
- R7: With control bit 1 at 0, a write to address 1 or 2 loads both that counter and its reload register. With bit 1 at 1, the write loads only the reload register, and the counter picks up the new value at its next underflow.
- R8: A write to address 1 or 2 while bit 1 is 0 and bit 0 is 1 sets the interrupt flag.
- R9: The external pin passes through two synchronizer flip-flops. With source 11, control bit 4 at 0 counts rising edges and at 1 counts falling edges. Each edge gives exactly one tick.
- R10: Address 0 reads the control register with the flag in bit 7. Addresses 1 and 2 read the live prescaler and main counter values, not the reload registers.
- R11: The interrupt flag stays set until a control write with bit 7 at 0. A set and a clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ring_en | input | 1 | On-chip oscillator tick enable (source 10) |
| ext_in | input | 1 | External count input pin (source 11), asynchronous |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 prescaler, 2 main |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request flag |

## Verification
The bench measures the first interrupt after starting from n=2 and m=3. A main counter that stepped on every tick, or a reload that gave n or m instead of n+1 or m+1 ticks, would raise the flag at the wrong count instead of at 12.

It counts external edges of each polarity through the synchronizer. A detector that fired on level or on both edges would leave the prescaler at the wrong value.

Reload-only writes are read back before and after the next underflow, which catches a design that loads the counter at once. Direct writes while running must raise the flag, and a control write with bit 7 high must not clear it.

// File: rtl/cprt_pkg.sv
package cprt_pkg;
  typedef enum logic [1:0] {
    SRC_CLK  = 2'b00,
    SRC_DIV8 = 2'b01,
    SRC_RING = 2'b10,
    SRC_EXT  = 2'b11
  } src_e;

  typedef struct packed {
    logic fall;
    src_e src;
    logic wmode;
    logic run;
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PRE  = 2'd1;
  localparam logic [1:0] ADDR_MAIN = 2'd2;
  localparam int         IRQ_BIT   = 7;
endpackage

// File: rtl/tick_select.sv
module tick_select
  import cprt_pkg::*;
#(
  parameter int DIV_LOG2 = 3,
  parameter int SYNC_N   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  src_e src,
  input  logic fall,
  input  logic ring_en,
  input  logic ext_in,
  output logic tick
);
  localparam logic [DIV_LOG2-1:0] DIV_TOP = '1;

  logic [DIV_LOG2-1:0] div_q, div_d;
  logic [SYNC_N-1:0]   sync_q, sync_d;
  logic                last_q, last_d;
  logic                ext_now, ext_edge;

  always_comb begin
    div_d  = div_q + 1'b1;
    sync_d = {sync_q[SYNC_N-2:0], ext_in};
    last_d = sync_q[SYNC_N-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign ext_now  = sync_q[SYNC_N-1];
  assign ext_edge = fall ? (last_q & ~ext_now) : (ext_now & ~last_q);

  always_comb begin
    unique case (src)
      SRC_CLK:  tick = 1'b1;
      SRC_DIV8: tick = (div_q == DIV_TOP);
      SRC_RING: tick = ring_en;
      default:  tick = ext_edge;
    endcase
  end

  assert_div_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_DIV8 && tick) |=> (src != SRC_DIV8 || !tick));

  assert_ext_single_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_EXT && tick) |=> (src != SRC_EXT || !tick));
endmodule

// File: rtl/reload_down_ctr.sv
module reload_down_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         wr_rel,
  input  logic         wr_cnt,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic         uf
);
  logic [W-1:0] cnt_q, cnt_d, rel_q, rel_d;

  always_comb begin
    uf    = step && (cnt_q == '0) && !wr_cnt;
    rel_d = wr_rel ? wdata : rel_q;
    cnt_d = cnt_q;
    if (wr_cnt)
      cnt_d = wdata;
    else if (step)
      cnt_d = (cnt_q == '0) ? rel_q : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      rel_q <= '1;
    end else begin
      cnt_q <= cnt_d;
      rel_q <= rel_d;
    end
  end

  assign cnt = cnt_q;

  assert_reload_on_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> cnt_q == $past(rel_q));

  assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_cnt) |=> cnt_q == $past(cnt_q));

  assert_reload_only_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rel && !wr_cnt && !step) |=> (cnt_q == $past(cnt_q) && rel_q == $past(wdata)));
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import cprt_pkg::*;
#(
  parameter int W        = 8,
  parameter int DIV_LOG2 = 3,
  parameter int SYNC_N   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ring_en,
  input  logic         ext_in,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         irq
);
  localparam int CW = $bits(ctrl_t);

  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  ctrl_t        ctrl_q, ctrl_d;
  logic         irq_q, irq_d;
  logic         wr_ctrl, wr_pre, wr_main, ld_pre, ld_main;
  logic         direct_wr, irq_set, irq_clr;
  logic         tick, step_pre, pre_uf, main_uf;
  logic [W-1:0] pre_cnt, main_cnt;
  logic         unused_bits;

  assign unused_bits = ^bus_wdata[IRQ_BIT-1:CW];

  always_comb begin
    wr_ctrl   = bus_wr && (bus_addr == ADDR_CTRL);
    wr_pre    = bus_wr && (bus_addr == ADDR_PRE);
    wr_main   = bus_wr && (bus_addr == ADDR_MAIN);
    ld_pre    = wr_pre  && !ctrl_q.wmode;
    ld_main   = wr_main && !ctrl_q.wmode;
    direct_wr = (wr_pre || wr_main) && !ctrl_q.wmode && ctrl_q.run;
    irq_clr   = wr_ctrl && !bus_wdata[IRQ_BIT];
    step_pre  = ctrl_q.run && tick;
    irq_set   = main_uf || direct_wr;
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = ctrl_t'(bus_wdata[CW-1:0]);
    irq_d = irq_q;
    if (irq_clr) irq_d = 1'b0;
    if (irq_set) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      irq_q  <= irq_d;
    end
  end

  tick_select #(.DIV_LOG2(DIV_LOG2), .SYNC_N(SYNC_N)) u_tick (
    .clk(clk), .rst_n(rst_i), .src(ctrl_q.src), .fall(ctrl_q.fall),
    .ring_en(ring_en), .ext_in(ext_in), .tick(tick)
  );

  reload_down_ctr #(.W(W)) u_pre (
    .clk(clk), .rst_n(rst_i), .step(step_pre), .wr_rel(wr_pre),
    .wr_cnt(ld_pre), .wdata(bus_wdata), .cnt(pre_cnt), .uf(pre_uf)
  );

  reload_down_ctr #(.W(W)) u_main (
    .clk(clk), .rst_n(rst_i), .step(pre_uf), .wr_rel(wr_main),
    .wr_cnt(ld_main), .wdata(bus_wdata), .cnt(main_cnt), .uf(main_uf)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_CTRL: begin
        bus_rdata[CW-1:0]  = ctrl_q;
        bus_rdata[IRQ_BIT] = irq_q;
      end
      ADDR_PRE:  bus_rdata = pre_cnt;
      ADDR_MAIN: bus_rdata = main_cnt;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq = irq_q;

  assert_main_steps_on_pre_uf_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (!pre_uf && !ld_main) |=> $stable(main_cnt));

  assert_irq_on_underflow_R6: assert property (@(posedge clk) disable iff (!rst_i)
    main_uf |=> irq_q);

  assert_direct_write_flag_R8: assert property (@(posedge clk) disable iff (!rst_i)
    direct_wr |=> irq_q);

  assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rst_i)
    (irq_q && !irq_clr) |=> irq_q);

  assert_stopped_prescaler_R5: assert property (@(posedge clk) disable iff (!rst_i)
    (!ctrl_q.run && !ld_pre) |=> $stable(pre_cnt));
endmodule

// File: tb/cascade_timer_tb.sv
`timescale 1ns/1ps
module cascade_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ring_en = 1'b0;
  logic       ext_in = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  cascade_timer dut_i (
    .clk(clk), .rst_n(rst_n), .ring_en(ring_en), .ext_in(ext_in),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // reference model state
  int m_rel = 0;
  int m_run, m_wm, m_src, m_fall, m_irq;
  int m_pre, m_prel, m_main, m_mrel, m_div;
  int s1, s2, s3;

  task automatic model_reset();
    m_run = 0; m_wm = 0; m_src = 0; m_fall = 0; m_irq = 0;
    m_pre = 255; m_prel = 255; m_main = 255; m_mrel = 255; m_div = 0;
    s1 = 0; s2 = 0; s3 = 0;
  endtask

  function automatic int exp_rdata(input int a);
    case (a)
      0: return (m_irq << 7) | (m_fall << 4) | (m_src << 2) | (m_wm << 1) | m_run;
      1: return m_pre;
      2: return m_main;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rel = 0; model_reset();
    end else if (m_rel < 2) begin
      m_rel++; model_reset();
    end else begin
      int tick, wp, wmn, wc, lp, lm, puf, muf, set, clr, edge_r, edge_f;
      edge_r = (s2 == 1 && s3 == 0);
      edge_f = (s2 == 0 && s3 == 1);
      case (m_src)
        0: tick = 1;
        1: tick = (m_div == 7);
        2: tick = ring_en;
        default: tick = m_fall ? edge_f : edge_r;
      endcase
      wc  = bus_wr && bus_addr == 0;
      wp  = bus_wr && bus_addr == 1;
      wmn = bus_wr && bus_addr == 2;
      lp  = wp && !m_wm;
      lm  = wmn && !m_wm;
      puf = m_run && tick && m_pre == 0 && !lp;
      muf = puf && m_main == 0 && !lm;
      set = muf || ((wp || wmn) && !m_wm && m_run);
      clr = wc && !bus_wdata[7];
      if (lp) m_pre = bus_wdata;
      else if (m_run && tick) m_pre = (m_pre == 0) ? m_prel : m_pre - 1;
      if (wp) m_prel = bus_wdata;
      if (lm) m_main = bus_wdata;
      else if (puf) m_main = (m_main == 0) ? m_mrel : m_main - 1;
      if (wmn) m_mrel = bus_wdata;
      if (clr) m_irq = 0;
      if (set) m_irq = 1;
      if (wc) begin
        m_run = bus_wdata[0]; m_wm = bus_wdata[1];
        m_src = bus_wdata[3:2]; m_fall = bus_wdata[4];
      end
      m_div = (m_div + 1) % 8;
      s3 = s2; s2 = s1; s1 = ext_in;
    end
    #3;
    if (rst_n && m_rel >= 2 && !done) begin
      chk(irq == m_irq, {phase, " R6 irq vs model"}, irq, m_irq);
      chk(bus_rdata == exp_rdata(bus_addr), {phase, " R10 rdata vs model"},
          bus_rdata, exp_rdata(bus_addr));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a[1:0]; bus_wdata = d[7:0];
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    bus_addr = a[1:0];
    @(posedge clk); #3;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_in = 1'b1; idle(4);
      ext_in = 1'b0; idle(4);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #500000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v, v2, n;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    phase = "R1";
    rd(0, v); chk(v == 8'h00, "R1 control after reset", v, 0);
    rd(1, v); chk(v == 8'hFF, "R1 prescaler after reset", v, 255);
    rd(2, v); chk(v == 8'hFF, "R1 main after reset", v, 255);
    rd(3, v); chk(v == 8'h00, "R1 address 3 reads zero", v, 0);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);

    // R3 period: n=2, m=3 -> 12 ticks
    phase = "R3";
    wr(1, 2); wr(2, 3);
    chk(irq == 1'b0, "R8 stopped direct write leaves irq clear", irq, 0);
    wr(0, 8'h01);
    n = 0;
    while (!irq && n < 100) begin @(posedge clk); #3; n++; end
    chk(n == 12, "R3 first interrupt after (n+1)(m+1) ticks", n, 12);
    phase = "R4"; idle(40);

    // R5 stop holds counters
    phase = "R5";
    wr(0, 8'h00);
    rd(2, v); rd(1, v2); idle(10);
    rd(2, n); chk(n == v, "R5 main held while stopped", n, v);
    rd(1, n); chk(n == v2, "R5 prescaler held while stopped", n, v2);

    // R7 reload-only writes
    phase = "R7";
    wr(0, 8'h02);
    rd(1, v);
    wr(1, 5);
    rd(1, n); chk(n == v, "R7 reload-only write leaves counter", n, v);
    wr(0, 8'h03);
    idle(v + 2);
    rd(1, n); chk(n <= 5, "R7 new reload in effect after underflow", n, 5);
    idle(30);

    // R2 other internal sources
    phase = "R2";
    wr(0, 8'h05); idle(120);
    wr(0, 8'h09);
    for (int i = 0; i < 120; i++) begin
      @(negedge clk); ring_en = (i % 3 == 0);
    end
    ring_en = 1'b0;

    // R9 external edges
    phase = "R9";
    wr(0, 8'h00); wr(1, 10); wr(0, 8'h0D);
    ext_pulses(3); idle(5);
    rd(1, v); chk(v == 7, "R9 three rising edges", v, 7);
    wr(0, 8'h00); wr(1, 10); wr(0, 8'h1D);
    ext_pulses(2); idle(5);
    rd(1, v); chk(v == 8, "R9 two falling edges", v, 8);

    // R8 / R11 direct write while running, sticky flag
    phase = "R8";
    wr(0, 8'h01); idle(2);
    wr(2, 50);
    chk(irq == 1'b1, "R8 direct write while running sets irq", irq, 1);
    phase = "R11";
    wr(0, 8'h80);
    chk(irq == 1'b1, "R11 control write with bit7=1 keeps irq", irq, 1);
    wr(0, 8'h00);
    chk(irq == 1'b0, "R11 control write with bit7=0 clears irq", irq, 0);
    wr(0, 8'h01); wr(2, 0); wr(1, 0);
    idle(20);
    wr(0, 8'h01); idle(5);
    idle(5);
    finish_run();
  end
endmodule